// File: doc/BRIEF.md
# Hamming SEC-DED Byte Codec

This block guards one 8-bit byte with a Hamming code plus an overall parity bit. It corrects any single flipped bit and detects any two flipped bits. The encoder turns a byte into five check bits. Those bits are stored next to the byte in whatever memory the surrounding design provides.

On the way back, the decoder takes the stored byte and its five check bits. It recomputes the Hamming bits and forms a syndrome that gives the code position of a flipped bit. It returns the byte, corrected where possible, and raises one of two flags: a correctable-error flag or an uncorrectable-error flag.

Both paths share one clock and one synchronous active-high reset. Each path has its own valid strobe, and its result appears one cycle after the input.

Top module: `secded_codec`

## Requirements
- R1: The byte sits in a 12-position code word. Data bit i occupies position 3, 5, 6, 7, 9, 10, 11 or 12 (bit 0 at position 3, bit 7 at position 12). Check bits enc_chk_o[0], [1], [2] and [3] sit at positions 1, 2, 4 and 8. Each is the even parity of the data positions whose index has that weight set.
- R2: enc_chk_o[4] makes the total count of ones over the byte and all five check bits even.
- R3: Byte 0xD2 encodes to check bits 5'b11011. Read from position 12 down to 1, the word is 110110010011.
- R4: On both paths, an output valid strobe is high exactly one cycle after the matching input strobe.
- R5: An intact word decodes to the stored byte, with both flags low.
- R6: A single flipped data bit is corrected, with dec_sec_o=1 and dec_ded_o=0.
- R7: A single flipped check bit, including the overall bit, leaves the byte unchanged and sets dec_sec_o=1.
- R8: When the syndrome is nonzero but overall parity holds (for example, two flips), dec_ded_o=1 and dec_sec_o=0. The byte passes through uncorrected.
- R9: A syndrome of 13 to 15 leaves the byte unchanged. It is flagged as correctable when overall parity fails, and as uncorrectable when overall parity holds.
- R10: After reset, both valid outputs and both flags are low.
- R11: In a cycle after an invalid decode input, both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_vld_i | input | 1 | Encode request |
| enc_data_i | input | 8 | Byte to encode |
| enc_vld_o | output | 1 | Encode result valid |
| enc_chk_o | output | 5 | {overall, P8, P4, P2, P1} |
| dec_vld_i | input | 1 | Decode request |
| dec_data_i | input | 8 | Stored byte |
| dec_chk_i | input | 5 | Stored check bits, same layout as enc_chk_o |
| dec_vld_o | output | 1 | Decode result valid |
| dec_data_o | output | 8 | Corrected or passed-through byte |
| dec_sec_o | output | 1 | Correctable error seen |
| dec_ded_o | output | 1 | Uncorrectable error seen |

## Verification
The assertions assume that a valid strobe and its data are applied together for a whole cycle, and that reset is held for at least one edge before the first strobe. Given that, the output byte can never differ from the input byte in more than one bit. It is identical to the input whenever the uncorrectable flag is raised.

The bench drives every input on the falling edge and holds it across the rising edge that captures it. It produces corrupted words only by flipping chosen bits of a known-good encoding, so the expected flag is always determined by how many bits were flipped and where.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Smallest number of Hamming bits r with 2^r >= dw + r + 1
  function automatic int ham_bits(input int dw);
    for (int r = 1; r < 8; r++)
      if ((1 << r) >= dw + r + 1) return r;
    return 8;
  endfunction

  // Code position (1-based) of data bit idx: skip powers of two
  function automatic int data_pos(input int idx);
    int cnt;
    cnt = 0;
    for (int p = 3; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  // Mask of data bits covered by Hamming bit j
  function automatic logic [63:0] cover_mask(input int j, input int dw);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < dw; i++)
      if (((data_pos(i) >> j) & 1) == 1) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/secded_hparity.sv
module secded_hparity
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int HAM_W = ham_bits(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W-1:0]  ham_o
);

  for (genvar j = 0; j < HAM_W; j++) begin : g_bit
    localparam logic [63:0] MASK = cover_mask(j, DATA_W);
    assign ham_o[j] = ^(data_i & MASK[DATA_W-1:0]);
  end

endmodule

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int HAM_W = ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [CHK_W-1:0]  chk_o
);

  logic [HAM_W-1:0] ham;
  logic             overall;

  secded_hparity #(.DATA_W(DATA_W)) u_hp (
    .data_i (data_i),
    .ham_o  (ham)
  );

  assign overall = (^data_i) ^ (^ham);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      chk_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) chk_o <= {overall, ham};
    end
  end

  p_enc_lat_r4: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);
  p_enc_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o);
  p_enc_even_r2: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (^{$past(data_i), chk_o}) == 1'b0);

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int HAM_W = ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);

  logic [HAM_W-1:0]  ham_calc;
  logic [HAM_W-1:0]  syn;
  logic              perr;
  logic [DATA_W-1:0] flip;

  secded_hparity #(.DATA_W(DATA_W)) u_hp (
    .data_i (data_i),
    .ham_o  (ham_calc)
  );

  assign syn  = ham_calc ^ chk_i[HAM_W-1:0];
  assign perr = ^{data_i, chk_i};

  // A data bit is flipped back only when overall parity fails and the
  // syndrome names exactly that bit's position.
  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
    assign flip[i] = perr && (syn == POS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      sec_o  <= 1'b0;
      ded_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      sec_o <= vld_i && perr;
      ded_o <= vld_i && !perr && (syn != '0);
      if (vld_i) data_o <= data_i ^ flip;
    end
  end

  p_dec_lat_r4: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(sec_o && ded_o));
  p_flags_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> (!sec_o && !ded_o));
  p_ded_pass_r8: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (!ded_o || data_o == $past(data_i)));
  p_clean_pass_r5: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (sec_o || ded_o || data_o == $past(data_i)));
  p_one_fix_r6: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> $countones(data_o ^ $past(data_i)) <= 1);

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = ham_bits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_vld_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_vld_o,
  output logic [CHK_W-1:0]  enc_chk_o,
  input  logic              dec_vld_i,
  input  logic [DATA_W-1:0] dec_data_i,
  input  logic [CHK_W-1:0]  dec_chk_i,
  output logic              dec_vld_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_sec_o,
  output logic              dec_ded_o
);

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (enc_vld_i),
    .data_i (enc_data_i),
    .vld_o  (enc_vld_o),
    .chk_o  (enc_chk_o)
  );

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (dec_vld_i),
    .data_i (dec_data_i),
    .chk_i  (dec_chk_i),
    .vld_o  (dec_vld_o),
    .data_o (dec_data_o),
    .sec_o  (dec_sec_o),
    .ded_o  (dec_ded_o)
  );

endmodule

// File: tb/tb_secded_codec.sv
module tb_secded_codec;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_vld_i = 1'b0;
  logic [7:0] enc_data_i = '0;
  logic       enc_vld_o;
  logic [4:0] enc_chk_o;
  logic       dec_vld_i = 1'b0;
  logic [7:0] dec_data_i = '0;
  logic [4:0] dec_chk_i = '0;
  logic       dec_vld_o;
  logic [7:0] dec_data_o;
  logic       dec_sec_o;
  logic       dec_ded_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  secded_codec dut (
    .clk(clk), .rst(rst),
    .enc_vld_i(enc_vld_i), .enc_data_i(enc_data_i),
    .enc_vld_o(enc_vld_o), .enc_chk_o(enc_chk_o),
    .dec_vld_i(dec_vld_i), .dec_data_i(dec_data_i), .dec_chk_i(dec_chk_i),
    .dec_vld_o(dec_vld_o), .dec_data_o(dec_data_o),
    .dec_sec_o(dec_sec_o), .dec_ded_o(dec_ded_o)
  );

  // Positions of data bits per R1
  function automatic int pos_of(input int i);
    case (i)
      0: return 3;  1: return 5;  2: return 6;  3: return 7;
      4: return 9;  5: return 10; 6: return 11; default: return 12;
    endcase
  endfunction

  function automatic logic [4:0] ref_chk(input logic [7:0] d);
    logic [4:0] c;
    c = '0;
    for (int j = 0; j < 4; j++)
      for (int i = 0; i < 8; i++)
        if (((pos_of(i) >> j) & 1) == 1) c[j] ^= d[i];
    c[4] = ^{d, c[3:0]};
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_enc(input logic [7:0] d, output logic [4:0] c);
    @(negedge clk);
    enc_vld_i = 1'b1; enc_data_i = d;
    @(negedge clk);
    enc_vld_i = 1'b0;
    c = enc_chk_o;
  endtask

  task automatic do_dec(input logic [7:0] d, input logic [4:0] c,
                        output logic [7:0] q, output logic s, output logic e);
    @(negedge clk);
    dec_vld_i = 1'b1; dec_data_i = d; dec_chk_i = c;
    @(negedge clk);
    dec_vld_i = 1'b0;
    q = dec_data_o; s = dec_sec_o; e = dec_ded_o;
  endtask

  task automatic t_reset;
    check(enc_vld_o == 0 && dec_vld_o == 0, "R10 valid", {enc_vld_o, dec_vld_o}, 0);
    check(dec_sec_o == 0 && dec_ded_o == 0, "R10 flags", {dec_sec_o, dec_ded_o}, 0);
  endtask

  task automatic t_example;
    logic [4:0] c;
    do_enc(8'hD2, c);
    check(c == 5'b11011, "R3 0xD2", c, 5'b11011);
    check(enc_vld_o == 1, "R4 enc valid", enc_vld_o, 1);
    @(negedge clk);
    check(enc_vld_o == 0, "R4 enc drop", enc_vld_o, 0);
  endtask

  task automatic t_sweep;
    logic [4:0] c;
    for (int v = 0; v < 256; v++) begin
      do_enc(8'(v), c);
      check(c[3:0] == ref_chk(8'(v)) [3:0], "R1 hamming", c, ref_chk(8'(v)));
      check(c[4] == ref_chk(8'(v)) [4], "R2 overall", c[4], ref_chk(8'(v)) [4]);
    end
  endtask

  task automatic t_clean;
    logic [7:0] q; logic s, e;
    logic [7:0] vals [4] = '{8'h00, 8'hFF, 8'hD2, 8'h5A};
    foreach (vals[k]) begin
      do_dec(vals[k], ref_chk(vals[k]), q, s, e);
      check(q == vals[k] && !s && !e, "R5 clean", {s, e, q}, vals[k]);
      check(dec_vld_o == 1, "R4 dec valid", dec_vld_o, 1);
    end
  endtask

  task automatic t_single_data;
    logic [7:0] q; logic s, e;
    logic [7:0] vals [3] = '{8'h00, 8'hD2, 8'hA7};
    foreach (vals[k])
      for (int i = 0; i < 8; i++) begin
        do_dec(vals[k] ^ (8'h1 << i), ref_chk(vals[k]), q, s, e);
        check(q == vals[k] && s && !e, "R6 data flip", {s, e, q}, {2'b10, vals[k]});
      end
  endtask

  task automatic t_single_check;
    logic [7:0] q; logic s, e;
    for (int j = 0; j < 5; j++) begin
      do_dec(8'h3C, ref_chk(8'h3C) ^ (5'h1 << j), q, s, e);
      check(q == 8'h3C && s && !e, "R7 check flip", {s, e, q}, {2'b10, 8'h3C});
    end
  endtask

  task automatic t_double;
    logic [7:0] q; logic s, e; logic [7:0] bad;
    bad = 8'hD2 ^ 8'h21;
    do_dec(bad, ref_chk(8'hD2), q, s, e);
    check(q == bad && !s && e, "R8 two data", {s, e, q}, {2'b01, bad});
    bad = 8'h96 ^ 8'h08;
    do_dec(bad, ref_chk(8'h96) ^ 5'b00100, q, s, e);
    check(q == bad && !s && e, "R8 data+check", {s, e, q}, {2'b01, bad});
  endtask

  task automatic t_unused;
    logic [7:0] q; logic s, e;
    // P1, P4, P8 flipped: syndrome 13, overall parity fails
    do_dec(8'hE1, ref_chk(8'hE1) ^ 5'b01101, q, s, e);
    check(q == 8'hE1 && s && !e, "R9 syn13 odd", {s, e, q}, {2'b10, 8'hE1});
    // P1, P2, P4, P8 flipped: syndrome 15, parity holds
    do_dec(8'h4B, ref_chk(8'h4B) ^ 5'b01111, q, s, e);
    check(q == 8'h4B && !s && e, "R9 syn15 even", {s, e, q}, {2'b01, 8'h4B});
  endtask

  task automatic t_idle;
    @(negedge clk);
    dec_vld_i = 1'b0; dec_data_i = 8'hFF; dec_chk_i = 5'b00000;
    @(negedge clk);
    check(!dec_sec_o && !dec_ded_o, "R11 idle flags", {dec_sec_o, dec_ded_o}, 0);
    check(!dec_vld_o, "R4 dec drop", dec_vld_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_example();
    t_sweep();
    t_clean();
    t_single_data();
    t_single_check();
    t_double();
    t_unused();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule